// File: doc/BRIEF.md
# Reed-Solomon Error Location Correction Applier

This block follows the syndrome and locator stage of a NAND flash read path. For each data chunk it accepts up to four error reports. Each report has a raw location and an 8-bit pattern whose set bits mark the bits that are wrong. Raw locations count backwards from the chunk end, and the smallest eight values land in the 10-byte parity tail. The block classifies every report. It mirrors the good ones into byte offsets, using a constant picked by the chunk-size mode. It then repairs each one in the page buffer with a read, a wait for the synchronous read data, and a write of the old byte XOR the pattern.

Software or a sequencer pulses start once per chunk. With the start pulse it supplies the chunk-size mode, the chunk's base offset in a buffer that holds the whole page, a per-report valid mask and the reports. When the last repair is written, the block pulses done. A count of repairs and a flag for locations beyond the valid range then stay steady until the next start. A page of several chunks, for example 2048 bytes, is handled by one run per chunk with a new base offset each time.

Top module: `ecc_fix_applier`

## Requirements
- R1: A valid report whose raw location is 0x000 to 0x007 lies in the parity tail. It causes no buffer access and does not add to the fix count.
- R2: With mode_512_i low (518-byte chunks), raw locations 0x008 to 0x20D are correctable, and the byte offset is 0x20D minus the raw value. For example, 0x083 gives 0x18A.
- R3: With mode_512_i high (512-byte chunks), raw locations 0x008 to 0x207 are correctable, and the byte offset is 0x207 minus the raw value. For example, 0x083 gives 0x184.
- R4: A repair writes the byte just read XOR the report's pattern. Only bits set in the pattern change; for example, pattern 0x81 flips bits 7 and 0.
- R5: The buffer address is base_off_i plus the byte offset, taken modulo 2^ADDR_W.
- R6: A valid report whose raw location is above the top of the selected mode's range sets uncorr_o, causes no buffer access and does not add to the fix count.
- R7: A valid report with an all-zero pattern is skipped: no buffer access and no count.
- R8: Each repair takes exactly three cycles: a read, then a wait cycle, then a write to the same address. Repairs follow report index order, lowest first. With n repairs, done_o is high for exactly one cycle, starting 3n+1 rising edges after start_i was sampled high. The start edge counts as the first of these edges.
- R9: fix_count_o and uncorr_o hold their values from done until the next accepted start. A start_i pulse while a run is in progress is ignored.
- R10: Report i is used only when rep_valid_i bit i is set. Report i occupies bits [i*10 +: 10] of rep_raw_i and bits [i*8 +: 8] of rep_pat_i. At most NUM_REP (4) reports are handled per chunk, and parity-tail reports still use one of those slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for one chunk; sampled only while idle |
| mode_512_i | input | 1 | 1: 512-byte chunk mapping, 0: 518-byte chunk mapping |
| base_off_i | input | ADDR_W | Buffer offset of the chunk's first byte |
| rep_valid_i | input | NUM_REP | Valid mask, one bit per report |
| rep_raw_i | input | NUM_REP*RAW_W | Raw error locations, report i at [i*RAW_W +: RAW_W] |
| rep_pat_i | input | NUM_REP*8 | Error patterns, report i at [i*8 +: 8] |
| buf_rd_en_o | output | 1 | Buffer read strobe |
| buf_wr_en_o | output | 1 | Buffer write strobe |
| buf_addr_o | output | ADDR_W | Buffer byte address |
| buf_wdata_o | output | 8 | Corrected byte |
| buf_rdata_i | input | 8 | Buffer read data, valid one cycle after the read strobe |
| done_o | output | 1 | One-cycle completion pulse |
| fix_count_o | output | CNT_W | Number of repairs written in the last run |
| uncorr_o | output | 1 | A valid report was above the mode's range in the last run |

## Verification
The bench uses the defaults ADDR_W=12, RAW_W=10 and NUM_REP=4. A 4096-byte buffer model therefore holds a full multi-chunk page, and a base offset near the top of the buffer exercises the address wrap. Because the raw field is 10 bits wide, random locations cover every class: the parity tail, both mapped ranges, and values above either top. With all four report slots in use, the bench can send duplicate locations that hit the same byte twice and mixes of repairable and skipped reports. It can also check the exact order of the writes.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;

  // Highest correctable raw location per chunk-size mode, and last parity code
  localparam int unsigned TOP_518  = 525;  // 0x20D
  localparam int unsigned TOP_512  = 519;  // 0x207
  localparam int unsigned PAR_LAST = 7;    // 0x007

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_WAIT  = 3'd2,
    ST_WRITE = 3'd3,
    ST_FIN   = 3'd4
  } fix_state_e;

  typedef struct packed {
    logic fixable;
    logic over;
  } rep_class_t;

endpackage

// File: rtl/ecc_rst_sync.sv
module ecc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/ecc_addr_map.sv
module ecc_addr_map
  import ecc_fix_pkg::*;
#(
  parameter int unsigned RAW_W  = 10,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              valid_i,
  input  logic              mode_512_i,
  input  logic [RAW_W-1:0]  raw_i,
  input  logic [7:0]        pat_i,
  input  logic [ADDR_W-1:0] base_i,
  output rep_class_t        class_o,
  output logic [ADDR_W-1:0] addr_o
);

  logic [RAW_W-1:0]  top_v;
  logic [RAW_W-1:0]  offset;
  logic              in_parity;
  logic              above_top;

  always_comb begin
    top_v     = mode_512_i ? RAW_W'(TOP_512) : RAW_W'(TOP_518);
    in_parity = (raw_i <= RAW_W'(PAR_LAST));
    above_top = (raw_i > top_v);
    offset    = top_v - raw_i;
    addr_o    = base_i + ADDR_W'(offset);
    class_o.fixable = valid_i && !in_parity && !above_top && (pat_i != 8'h00);
    class_o.over    = valid_i && above_top;
  end

endmodule

// File: rtl/ecc_first_pick.sv
module ecc_first_pick #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     oh_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);

  logic found;

  always_comb begin
    oh_o  = '0;
    idx_o = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !found) begin
        oh_o[i] = 1'b1;
        idx_o   = IDX_W'(i);
        found   = 1'b1;
      end
    end
    any_o = |req_i;
  end

  // R8: one report served at a time, in index order
  always_comb begin
    if (!$isunknown(req_i)) begin
      p_pick_onehot_r8: assert ($onehot0(oh_o) && (oh_o == (req_i & ~(req_i - N'(1)))));
    end
  end

endmodule

// File: rtl/ecc_fix_applier.sv
module ecc_fix_applier
  import ecc_fix_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned RAW_W   = 10,
  parameter int unsigned NUM_REP = 4,
  parameter int unsigned CNT_W   = $clog2(NUM_REP + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic                       mode_512_i,
  input  logic [ADDR_W-1:0]          base_off_i,
  input  logic [NUM_REP-1:0]         rep_valid_i,
  input  logic [NUM_REP*RAW_W-1:0]   rep_raw_i,
  input  logic [NUM_REP*8-1:0]       rep_pat_i,
  output logic                       buf_rd_en_o,
  output logic                       buf_wr_en_o,
  output logic [ADDR_W-1:0]          buf_addr_o,
  output logic [7:0]                 buf_wdata_o,
  input  logic [7:0]                 buf_rdata_i,
  output logic                       done_o,
  output logic [CNT_W-1:0]           fix_count_o,
  output logic                       uncorr_o
);

  localparam int unsigned IDX_W = (NUM_REP > 1) ? $clog2(NUM_REP) : 1;

  logic rst_sync_n;

  ecc_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Per-report classification and address mapping
  rep_class_t              cls   [NUM_REP];
  logic [ADDR_W-1:0]       map_a [NUM_REP];
  logic [NUM_REP-1:0]      fix_vec;
  logic [NUM_REP-1:0]      over_vec;

  for (genvar g = 0; g < NUM_REP; g++) begin : g_map
    ecc_addr_map #(
      .RAW_W  (RAW_W),
      .ADDR_W (ADDR_W)
    ) u_map (
      .valid_i    (rep_valid_i[g]),
      .mode_512_i (mode_512_i),
      .raw_i      (rep_raw_i[g*RAW_W +: RAW_W]),
      .pat_i      (rep_pat_i[g*8 +: 8]),
      .base_i     (base_off_i),
      .class_o    (cls[g]),
      .addr_o     (map_a[g])
    );
    assign fix_vec[g]  = cls[g].fixable;
    assign over_vec[g] = cls[g].over;
  end

  // State
  fix_state_e          state_q, state_d;
  logic [NUM_REP-1:0]  pend_q, pend_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic                unc_q, unc_d;
  logic [7:0]          rdat_q;
  logic [ADDR_W-1:0]   addr_q [NUM_REP];
  logic [7:0]          pat_q  [NUM_REP];

  logic                cap_en;
  logic                rdat_en;
  logic                stat_en;

  // Next report to serve
  logic [NUM_REP-1:0]  pick_oh;
  logic [IDX_W-1:0]    pick_idx;
  logic                pick_any;
  logic [NUM_REP-1:0]  pend_left;

  ecc_first_pick #(
    .N     (NUM_REP),
    .IDX_W (IDX_W)
  ) u_pick (
    .req_i (pend_q),
    .oh_o  (pick_oh),
    .idx_o (pick_idx),
    .any_o (pick_any)
  );

  assign pend_left = pend_q & ~pick_oh;

  // Next-state logic
  always_comb begin
    state_d     = state_q;
    pend_d      = pend_q;
    cnt_d       = cnt_q;
    unc_d       = unc_q;
    cap_en      = 1'b0;
    rdat_en     = 1'b0;
    stat_en     = 1'b0;
    buf_rd_en_o = 1'b0;
    buf_wr_en_o = 1'b0;
    buf_addr_o  = addr_q[pick_idx];
    buf_wdata_o = rdat_q ^ pat_q[pick_idx];
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          cap_en  = 1'b1;
          stat_en = 1'b1;
          pend_d  = fix_vec;
          cnt_d   = '0;
          unc_d   = |over_vec;
          state_d = (|fix_vec) ? ST_READ : ST_FIN;
        end
      end
      ST_READ: begin
        buf_rd_en_o = pick_any;
        state_d     = ST_WAIT;
      end
      ST_WAIT: begin
        rdat_en = 1'b1;
        state_d = ST_WRITE;
      end
      ST_WRITE: begin
        buf_wr_en_o = 1'b1;
        stat_en     = 1'b1;
        pend_d      = pend_left;
        cnt_d       = cnt_q + CNT_W'(1);
        state_d     = (|pend_left) ? ST_READ : ST_FIN;
      end
      ST_FIN: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      cnt_q   <= '0;
      unc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (stat_en) begin
        pend_q <= pend_d;
        cnt_q  <= cnt_d;
        unc_q  <= unc_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rdat_en) rdat_q <= buf_rdata_i;
  end

  for (genvar g = 0; g < NUM_REP; g++) begin : g_cap
    always_ff @(posedge clk) begin
      if (cap_en) begin
        addr_q[g] <= map_a[g];
        pat_q[g]  <= rep_pat_i[g*8 +: 8];
      end
    end
  end

  assign done_o      = (state_q == ST_FIN);
  assign fix_count_o = cnt_q;
  assign uncorr_o    = unc_q;

  // Assertions
  // R8: a write repeats the address read two cycles earlier
  p_rmw_same_addr_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    buf_wr_en_o |-> ($past(buf_rd_en_o, 2) && ($past(buf_addr_o, 2) == buf_addr_o)));

  // R8: done is a single-cycle pulse
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |=> !done_o);

  // R8: never read and write together
  p_one_access_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(buf_rd_en_o && buf_wr_en_o));

  // R4 / R7: the written byte differs from the byte read (nonzero pattern)
  p_write_changes_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    buf_wr_en_o |-> (buf_wdata_o != $past(buf_rdata_i)));

  // R9: results hold while idle with no start
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_o || (state_q == ST_IDLE && !start_i)) |=> ($stable(fix_count_o) && $stable(uncorr_o)));

  // R10: no more repairs than report slots
  p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fix_count_o <= CNT_W'(NUM_REP));

endmodule

// File: tb/ecc_fix_applier_tb_top.sv
`timescale 1ns/1ps
module ecc_fix_applier_tb_top;

  localparam int ADDR_W = 12;
  localparam int RAW_W  = 10;
  localparam int NREP   = 4;
  localparam int CNT_W  = 3;
  localparam int MEMSZ  = 1 << ADDR_W;

  logic                  clk = 1'b0;
  logic                  rst_n;
  logic                  start;
  logic                  mode_512;
  logic [ADDR_W-1:0]     base_off;
  logic [NREP-1:0]       rep_valid;
  logic [NREP*RAW_W-1:0] rep_raw;
  logic [NREP*8-1:0]     rep_pat;
  logic                  rd_en, wr_en;
  logic [ADDR_W-1:0]     addr;
  logic [7:0]            wdata;
  logic [7:0]            rdata;
  logic                  done;
  logic [CNT_W-1:0]      fix_count;
  logic                  uncorr;

  always #4 clk = ~clk;

  ecc_fix_applier #(
    .ADDR_W  (ADDR_W),
    .RAW_W   (RAW_W),
    .NUM_REP (NREP),
    .CNT_W   (CNT_W)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .mode_512_i  (mode_512),
    .base_off_i  (base_off),
    .rep_valid_i (rep_valid),
    .rep_raw_i   (rep_raw),
    .rep_pat_i   (rep_pat),
    .buf_rd_en_o (rd_en),
    .buf_wr_en_o (wr_en),
    .buf_addr_o  (addr),
    .buf_wdata_o (wdata),
    .buf_rdata_i (rdata),
    .done_o      (done),
    .fix_count_o (fix_count),
    .uncorr_o    (uncorr)
  );

  // Buffer model: synchronous read, write on clock edge
  logic [7:0] mem    [MEMSZ];
  logic [7:0] shadow [MEMSZ];
  int         wlog   [1024];
  int         wlog_n = 0;

  always @(posedge clk) begin
    if (rd_en) rdata <= mem[addr];
    if (wr_en) begin
      mem[addr] <= wdata;
      if (wlog_n < 1024) wlog[wlog_n] <= int'(addr);
      wlog_n <= wlog_n + 1;
    end
  end

  int n_checks = 0;
  int n_fail   = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Expected mapping from the requirements (R1, R2, R3, R6, R7)
  function automatic void exp_map(input logic [RAW_W-1:0] raw, input bit m512, input logic [7:0] pat,
                                  input logic [ADDR_W-1:0] base,
                                  output bit fixable, output bit over, output int a);
    int top;
    top     = m512 ? 'h207 : 'h20D;
    over    = int'(raw) > top;
    fixable = (int'(raw) >= 8) && !over && (pat != 8'h00);
    a       = (int'(base) + top - int'(raw)) % MEMSZ;
  endfunction

  logic [RAW_W-1:0] c_raw [NREP];
  logic [7:0]       c_pat [NREP];

  task automatic run_case(input string tag, input bit m512, input logic [ADDR_W-1:0] base,
                          input logic [NREP-1:0] vld, input bit poke);
    int  exp_addr [NREP];
    int  n_exp;
    bit  exp_unc;
    int  cyc;
    int  w0;
    int  bad;
    int  bad_a;
    bit  f, o;
    int  a;
    logic [CNT_W-1:0] cnt_keep;
    logic             unc_keep;

    n_exp   = 0;
    exp_unc = 1'b0;
    for (int i = 0; i < NREP; i++) begin
      exp_map(c_raw[i], m512, c_pat[i], base, f, o, a);
      if (vld[i] && o) exp_unc = 1'b1;
      if (vld[i] && f) begin
        exp_addr[n_exp] = a;
        n_exp++;
        shadow[a] = shadow[a] ^ c_pat[i];
      end
    end

    @(negedge clk);
    mode_512  = m512;
    base_off  = base;
    rep_valid = vld;
    for (int i = 0; i < NREP; i++) begin
      rep_raw[i*RAW_W +: RAW_W] = c_raw[i];
      rep_pat[i*8 +: 8]         = c_pat[i];
    end
    start = 1'b1;
    w0    = wlog_n;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc   = 1;
    while (!done && cyc < 60) begin
      if (poke && cyc == 1) begin
        start     = 1'b1;
        rep_valid = '1;
        rep_raw   = '0;
        rep_pat   = '1;
        base_off  = ~base;
      end else begin
        start = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(cyc == 3*n_exp + 1, "R8", {tag, " done latency"}, cyc, 3*n_exp + 1);
    @(posedge clk);
    @(negedge clk);
    chk(!done, "R8", {tag, " done width"}, int'(done), 0);
    chk(int'(fix_count) == n_exp, poke ? "R9" : "R7", {tag, " fix count"}, int'(fix_count), n_exp);
    chk(uncorr == exp_unc, "R6", {tag, " uncorr flag"}, int'(uncorr), int'(exp_unc));
    chk(wlog_n - w0 == n_exp, "R1", {tag, " write count"}, wlog_n - w0, n_exp);
    for (int k = 0; k < n_exp; k++) begin
      if (w0 + k < wlog_n && w0 + k < 1024)
        chk(wlog[w0 + k] == exp_addr[k], "R8", {tag, " write order/address"}, wlog[w0 + k], exp_addr[k]);
    end
    bad   = 0;
    bad_a = 0;
    for (int i = 0; i < MEMSZ; i++) begin
      if (mem[i] !== shadow[i]) begin
        if (bad == 0) bad_a = i;
        bad++;
      end
    end
    chk(bad == 0, "R4", {tag, " buffer contents (first bad addr)"}, bad == 0 ? 0 : int'(mem[bad_a]),
        bad == 0 ? 0 : int'(shadow[bad_a]));
    // R9: results hold while idle
    cnt_keep  = fix_count;
    unc_keep  = uncorr;
    rep_valid = '1;
    rep_raw   = {NREP{10'h3FF}};
    mode_512  = ~m512;
    repeat (4) @(negedge clk);
    chk(fix_count == cnt_keep && uncorr == unc_keep, "R9", {tag, " hold after done"},
        int'({fix_count, uncorr}), int'({cnt_keep, unc_keep}));
  endtask

  task automatic set_rep(input int i, input logic [RAW_W-1:0] r, input logic [7:0] p);
    c_raw[i] = r;
    c_pat[i] = p;
  endtask

  task automatic clear_reps();
    for (int i = 0; i < NREP; i++) set_rep(i, 10'h000, 8'h00);
  endtask

  initial begin
    #(8 * 150000);
    chk(1'b0, "R8", "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < MEMSZ; i++) begin
      mem[i]    = 8'((i * 37) ^ 8'h5A);
      shadow[i] = 8'((i * 37) ^ 8'h5A);
    end
    rst_n     = 1'b0;
    start     = 1'b0;
    mode_512  = 1'b0;
    base_off  = '0;
    rep_valid = '0;
    rep_raw   = '0;
    rep_pat   = '0;
    repeat (3) @(negedge clk);
    chk(!done && !rd_en && !wr_en, "R8", "reset: no access, no done", int'({done, rd_en, wr_en}), 0);
    chk(fix_count == 0 && !uncorr, "R9", "reset: status cleared", int'({fix_count, uncorr}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: parity tail location, no write
    clear_reps(); set_rep(0, 10'h005, 8'h04);
    run_case("R1 parity", 1'b0, 12'h000, 4'b0001, 1'b0);
    // R2: 518-byte mapping
    clear_reps(); set_rep(0, 10'h083, 8'h81);
    run_case("R2 map518", 1'b0, 12'h000, 4'b0001, 1'b0);
    // R2: range ends
    clear_reps(); set_rep(0, 10'h20D, 8'h10); set_rep(1, 10'h008, 8'h02);
    run_case("R2 ends", 1'b0, 12'h000, 4'b0011, 1'b0);
    // R3: 512-byte mapping
    clear_reps(); set_rep(0, 10'h083, 8'h81);
    run_case("R3 map512", 1'b1, 12'h000, 4'b0001, 1'b0);
    // R3 / R6: top of 512 mode, one past it
    clear_reps(); set_rep(0, 10'h207, 8'h40); set_rep(1, 10'h208, 8'h01);
    run_case("R6 over512", 1'b1, 12'h000, 4'b0011, 1'b0);
    // R6: above 518 top
    clear_reps(); set_rep(2, 10'h20E, 8'hFF); set_rep(3, 10'h100, 8'h08);
    run_case("R6 over518", 1'b0, 12'h200, 4'b1100, 1'b0);
    // R7: zero pattern skipped
    clear_reps(); set_rep(0, 10'h050, 8'h00); set_rep(1, 10'h060, 8'h20);
    run_case("R7 zeropat", 1'b0, 12'h000, 4'b0011, 1'b0);
    // R5: base offset and wrap
    clear_reps(); set_rep(0, 10'h083, 8'h81);
    run_case("R5 base", 1'b0, 12'h600, 4'b0001, 1'b0);
    clear_reps(); set_rep(0, 10'h083, 8'h0F); set_rep(1, 10'h010, 8'hF0);
    run_case("R5 wrap", 1'b0, 12'hF80, 4'b0011, 1'b0);
    // R4: all slots, duplicate byte
    clear_reps(); set_rep(0, 10'h100, 8'h11); set_rep(1, 10'h100, 8'h33);
    set_rep(2, 10'h003, 8'h44); set_rep(3, 10'h1FF, 8'hA5);
    run_case("R4 dup", 1'b0, 12'h208, 4'b1111, 1'b0);
    // R10: valid mask gates reports
    clear_reps(); set_rep(0, 10'h090, 8'h01); set_rep(1, 10'h091, 8'h02);
    set_rep(2, 10'h092, 8'h04); set_rep(3, 10'h093, 8'h08);
    run_case("R10 mask", 1'b1, 12'h400, 4'b1010, 1'b0);
    run_case("R10 none", 1'b1, 12'h400, 4'b0000, 1'b0);
    // R9: start while busy ignored
    clear_reps(); set_rep(0, 10'h0A0, 8'h3C); set_rep(3, 10'h0B0, 8'hC3);
    run_case("R9 poke", 1'b0, 12'h800, 4'b1001, 1'b1);

    // Random chunks
    for (int t = 0; t < 40; t++) begin
      bit m;
      m = 1'($urandom % 2);
      for (int i = 0; i < NREP; i++) begin
        int s;
        int topv;
        logic [RAW_W-1:0] r;
        logic [7:0] p;
        topv = m ? 'h207 : 'h20D;
        s = int'($urandom % 8);
        if (s == 0)      r = RAW_W'($urandom % 8);
        else if (s == 1) r = RAW_W'($urandom % 1024);
        else             r = RAW_W'(8 + ($urandom % (topv - 7)));
        p = ($urandom % 6 == 0) ? 8'h00 : 8'($urandom);
        set_rep(i, r, p);
      end
      run_case("random", m, ADDR_W'($urandom), NREP'($urandom), 1'($urandom % 5 == 0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule